// File: doc/BRIEF.md
# Multi-Line Serial Receive Queue

This block is the receive half of a four-line serial multiplexer. Each line's deserializer presents a finished character with its framing and parity flags. The block filters that character through the line's receiver enable and character size. It then places the character into a single shared queue, tagged with its line number and error flags. Software drains the queue through one receive word, and each read strobe removes the oldest entry.

A parameter write port carries the target line number in its low bits. The configuration fields sit above the line number. The stored per-line configuration is driven out on `lineCfg` for the line receivers and baud logic. The block raises a receive-done status whenever the queue holds data. The interrupt output combines receive-done with the interrupt enable input.

Top module: `mux_rx_queue`

## Requirements
- R1: After reset the queue is empty, `bufWord` reads 0, `rxDone` and `rxIrq` are 0, and every line's configuration reads 0x1C3 (8-bit characters, baud code 14, receiver disabled).
- R2: A strobe on `lprWrite` with line number L in `lprData[1:0]` loads the configuration field `lprData[11:2]` into line L only. The new value is visible on `lineCfg[L*10 +: 10]` after that clock edge. Without the strobe no configuration changes. Configuration bit layout: [1:0] size code (0..3 meaning 5..8 bits), [2] two stop bits, [3] parity enable, [4] odd parity, [8:5] baud code, [9] receiver enable.
- R3: Baud codes 0 to 14 select the fifteen supported rates. A write carrying baud code 15 leaves that line's baud code unchanged and still updates its other fields.
- R4: A character that arrives on a line whose receiver enable bit is 0 is discarded and never enters the queue.
- R5: A stored character keeps only its low 5+size-code bits, and the unused upper bits read as zero.
- R6: Receive word layout: [15] data valid, [14] overrun, [13] framing error, [12] parity error, [9:8] line number, [7:0] character, and all other bits 0. A character sampled at clock edge E is at the head of an empty queue after edge E+2.
- R7: Entries leave in arrival order. Characters that arrive on several lines in the same cycle are queued in ascending line order.
- R8: A `bufRead` strobe while the word is valid removes the head entry. A strobe on an empty queue has no effect, and the word then reads with the valid bit 0.
- R9: The queue holds 64 entries. A character that finds it full is dropped, the stored entries stay intact, and the next entry stored afterwards carries the overrun bit.
- R10: `rxDone` is high exactly when the queue is not empty, and it changes on the cycle after the push or pop that changes that state.
- R11: `rxIrq` is high only while both `rxDone` and `rxIntEn` are high.
- R12: The framing and parity flags of an arriving character are stored with it. A null character with a framing error, which marks a line break, is queued with a zero character and the framing bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxValid | input | 4 | One-cycle character-ready strobe per line |
| rxChar | input | 32 | Received character per line, line n at [8n+7:8n] |
| rxFrameErr | input | 4 | Framing error flag per line |
| rxParityErr | input | 4 | Parity error flag per line |
| lprWrite | input | 1 | Line parameter write strobe |
| lprData | input | 12 | Target line in [1:0], configuration in [11:2] |
| bufRead | input | 1 | Pop strobe for the receive word |
| rxIntEn | input | 1 | Receive interrupt enable |
| bufWord | output | 16 | Head entry of the queue, with its valid flag |
| rxDone | output | 1 | Queue not empty |
| rxIrq | output | 1 | Receive interrupt |
| lineCfg | output | 40 | Per-line configuration, line n at [10n+9:10n] |

## Verification
The assertions take for granted that no line strobes `rxValid` more often than once every four cycles. Under that condition each line's one-character holding slot has drained before the next arrival. That is what makes the receive-done rise a fixed two cycles after an arrival. They also take `bufRead` as a single-cycle pulse issued against the word currently shown. The directed tasks space every arrival on a line by at least four cycles and pulse the read strobe for exactly one cycle. The simultaneous-arrival scenario uses one character per line.

// File: rtl/mux_rx_pkg.sv
package mux_rx_pkg;

  // receive word layout
  localparam int WORD_W    = 16;
  localparam int CHAR_W    = 8;
  localparam int BIT_VALID = 15;
  localparam int BIT_OVR   = 14;
  localparam int BIT_FRM   = 13;
  localparam int BIT_PAR   = 12;
  localparam int LINE_LSB  = 8;

  // per-line configuration layout
  localparam int CFG_W        = 10;
  localparam int CFG_SIZE_LSB = 0;
  localparam int CFG_STOP     = 2;
  localparam int CFG_PEN      = 3;
  localparam int CFG_PODD     = 4;
  localparam int CFG_BAUD_LSB = 5;
  localparam int CFG_BAUD_W   = 4;
  localparam int CFG_EN       = 9;
  localparam logic [CFG_BAUD_W-1:0] BAUD_RESERVED = 4'hF;
  localparam logic [CFG_W-1:0]      CFG_RESET     = 10'h1C3;

  // control-to-datapath strobes
  typedef struct packed {
    logic take;    // a holding slot is consumed this cycle
    logic push;    // consumed slot is written into the queue
    logic pop;     // head entry leaves the queue
    logic ovrTag;  // stored entry must carry the overrun flag
  } rx_strobe_t;

endpackage

// File: rtl/mux_rx_ctrl.sv
module mux_rx_ctrl
  import mux_rx_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int QDEPTH    = 64,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] holdFull,
  input  logic                 bufRead,
  output rx_strobe_t           strb,
  output logic [LW-1:0]        selLine,
  output logic [AW-1:0]        wrPtr,
  output logic [AW-1:0]        rdPtr,
  output logic                 notEmpty
);

  logic [AW:0] count;
  logic        qFull;
  logic        ovrPend;
  logic        found;

  // fixed priority: lowest line index drains first
  always_comb begin
    selLine = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (holdFull[i] && !found) begin
        selLine = LW'(i);
        found   = 1'b1;
      end
    end
  end

  assign qFull    = (count == (AW+1)'(QDEPTH));
  assign notEmpty = (count != '0);

  always_comb begin
    strb.take   = |holdFull;
    strb.push   = strb.take && !qFull;
    strb.pop    = bufRead && notEmpty;
    strb.ovrTag = ovrPend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      ovrPend <= 1'b0;
    end else begin
      if (strb.push)
        wrPtr <= (wrPtr == AW'(QDEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop)
        rdPtr <= (rdPtr == AW'(QDEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strb.take && qFull)
        ovrPend <= 1'b1;
      else if (strb.push)
        ovrPend <= 1'b0;
    end
  end

endmodule

// File: rtl/mux_rx_dp.sv
module mux_rx_dp
  import mux_rx_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int QDEPTH    = 64,
  localparam int LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int LPR_W = LW + CFG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        rxValid,
  input  logic [NUM_LINES*CHAR_W-1:0] rxChar,
  input  logic [NUM_LINES-1:0]        rxFrameErr,
  input  logic [NUM_LINES-1:0]        rxParityErr,
  input  logic                        lprWrite,
  input  logic [LPR_W-1:0]            lprData,
  input  rx_strobe_t                  strb,
  input  logic [LW-1:0]               selLine,
  input  logic [AW-1:0]               wrPtr,
  input  logic [AW-1:0]               rdPtr,
  input  logic                        notEmpty,
  output logic [NUM_LINES-1:0]        holdFull,
  output logic [WORD_W-1:0]           bufWord,
  output logic [NUM_LINES*CFG_W-1:0]  lineCfg
);

  logic [CFG_W-1:0]  cfgReg   [NUM_LINES];
  logic [CHAR_W-1:0] holdChar [NUM_LINES];
  logic              holdFrm  [NUM_LINES];
  logic              holdPar  [NUM_LINES];
  logic              holdOvr  [NUM_LINES];
  logic [WORD_W-1:0] mem      [QDEPTH];
  logic [WORD_W-1:0] entry;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [CFG_W-1:0]  nextCfg;
    logic [CHAR_W-1:0] sizeMask;
    logic              takenHere;

    // reserved baud code keeps the previous rate
    always_comb begin
      nextCfg = lprData[LW +: CFG_W];
      if (nextCfg[CFG_BAUD_LSB +: CFG_BAUD_W] == BAUD_RESERVED)
        nextCfg[CFG_BAUD_LSB +: CFG_BAUD_W] = cfgReg[g][CFG_BAUD_LSB +: CFG_BAUD_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        cfgReg[g] <= CFG_RESET;
      else if (lprWrite && (lprData[LW-1:0] == LW'(g)))
        cfgReg[g] <= nextCfg;
    end

    assign sizeMask  = 8'hFF >> (2'd3 - cfgReg[g][CFG_SIZE_LSB +: 2]);
    assign takenHere = strb.take && (selLine == LW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        holdFull[g] <= 1'b0;
        holdChar[g] <= '0;
        holdFrm[g]  <= 1'b0;
        holdPar[g]  <= 1'b0;
        holdOvr[g]  <= 1'b0;
      end else if (rxValid[g] && cfgReg[g][CFG_EN]) begin
        holdFull[g] <= 1'b1;
        holdChar[g] <= rxChar[g*CHAR_W +: CHAR_W] & sizeMask;
        holdFrm[g]  <= rxFrameErr[g];
        holdPar[g]  <= rxParityErr[g];
        holdOvr[g]  <= holdFull[g] && !takenHere;
      end else if (takenHere) begin
        holdFull[g] <= 1'b0;
      end
    end

    assign lineCfg[g*CFG_W +: CFG_W] = cfgReg[g];
  end

  always_comb begin
    entry                     = '0;
    entry[CHAR_W-1:0]         = holdChar[selLine];
    entry[LINE_LSB +: LW]     = selLine;
    entry[BIT_PAR]            = holdPar[selLine];
    entry[BIT_FRM]            = holdFrm[selLine];
    entry[BIT_OVR]            = holdOvr[selLine] | strb.ovrTag;
  end

  always_ff @(posedge clk) begin
    if (strb.push)
      mem[wrPtr] <= entry;
  end

  always_comb begin
    bufWord = '0;
    if (notEmpty) begin
      bufWord            = mem[rdPtr];
      bufWord[BIT_VALID] = 1'b1;
    end
  end

endmodule

// File: rtl/mux_rx_queue.sv
module mux_rx_queue
  import mux_rx_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int QDEPTH    = 64,
  localparam int LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int AW    = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int LPR_W = LW + CFG_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        rxValid,
  input  logic [NUM_LINES*CHAR_W-1:0] rxChar,
  input  logic [NUM_LINES-1:0]        rxFrameErr,
  input  logic [NUM_LINES-1:0]        rxParityErr,
  input  logic                        lprWrite,
  input  logic [LPR_W-1:0]            lprData,
  input  logic                        bufRead,
  input  logic                        rxIntEn,
  output logic [WORD_W-1:0]           bufWord,
  output logic                        rxDone,
  output logic                        rxIrq,
  output logic [NUM_LINES*CFG_W-1:0]  lineCfg
);

  rx_strobe_t           strb;
  logic [LW-1:0]        selLine;
  logic [AW-1:0]        wrPtr;
  logic [AW-1:0]        rdPtr;
  logic                 notEmpty;
  logic [NUM_LINES-1:0] holdFull;

  mux_rx_ctrl #(.NUM_LINES(NUM_LINES), .QDEPTH(QDEPTH)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .holdFull (holdFull),
    .bufRead  (bufRead),
    .strb     (strb),
    .selLine  (selLine),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .notEmpty (notEmpty)
  );

  mux_rx_dp #(.NUM_LINES(NUM_LINES), .QDEPTH(QDEPTH)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxValid     (rxValid),
    .rxChar      (rxChar),
    .rxFrameErr  (rxFrameErr),
    .rxParityErr (rxParityErr),
    .lprWrite    (lprWrite),
    .lprData     (lprData),
    .strb        (strb),
    .selLine     (selLine),
    .wrPtr       (wrPtr),
    .rdPtr       (rdPtr),
    .notEmpty    (notEmpty),
    .holdFull    (holdFull),
    .bufWord     (bufWord),
    .lineCfg     (lineCfg)
  );

  assign rxDone = notEmpty;
  assign rxIrq  = notEmpty && rxIntEn;

endmodule

// File: rtl/mux_rx_chk.sv
module mux_rx_chk
  import mux_rx_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int LW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int LPR_W = LW + CFG_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_LINES-1:0]       rxValid,
  input logic                       lprWrite,
  input logic                       bufRead,
  input logic                       rxIntEn,
  input logic [WORD_W-1:0]          bufWord,
  input logic                       rxDone,
  input logic                       rxIrq,
  input logic [NUM_LINES*CFG_W-1:0] lineCfg
);

  AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lprWrite |=> $stable(lineCfg)); // R2

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bufWord[BIT_VALID] && !bufRead) |=> $stable(bufWord)); // R8

  AST_DONE_MATCHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rxDone == bufWord[BIT_VALID]); // R10

  AST_DONE_RISE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxDone) |-> $past(|rxValid, 2)); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> (rxIntEn && rxDone)); // R11

endmodule

bind mux_rx_queue mux_rx_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rxValid  (rxValid),
  .lprWrite (lprWrite),
  .bufRead  (bufRead),
  .rxIntEn  (rxIntEn),
  .bufWord  (bufWord),
  .rxDone   (rxDone),
  .rxIrq    (rxIrq),
  .lineCfg  (lineCfg)
);

// File: tb/mux_rx_queue_tb_top.sv
module mux_rx_queue_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rxValid = '0;
  logic [31:0] rxChar = '0;
  logic [3:0]  rxFrameErr = '0;
  logic [3:0]  rxParityErr = '0;
  logic        lprWrite = 1'b0;
  logic [11:0] lprData = '0;
  logic        bufRead = 1'b0;
  logic        rxIntEn = 1'b0;
  logic [15:0] bufWord;
  logic        rxDone;
  logic        rxIrq;
  logic [39:0] lineCfg;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  mux_rx_queue dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxValid     (rxValid),
    .rxChar      (rxChar),
    .rxFrameErr  (rxFrameErr),
    .rxParityErr (rxParityErr),
    .lprWrite    (lprWrite),
    .lprData     (lprData),
    .bufRead     (bufRead),
    .rxIntEn     (rxIntEn),
    .bufWord     (bufWord),
    .rxDone      (rxDone),
    .rxIrq       (rxIrq),
    .lineCfg     (lineCfg)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] mkCfg(input logic en, input logic [3:0] baud,
      input logic podd, input logic pen, input logic stop, input logic [1:0] size);
    return {en, baud, podd, pen, stop, size};
  endfunction

  task automatic cfgWrite(input logic [1:0] line, input logic [9:0] cfg);
    lprData  = {cfg, line};
    lprWrite = 1'b1;
    @(negedge clk);
    lprWrite = 1'b0;
  endtask

  task automatic sendMany(input logic [3:0] mask, input logic [31:0] chars,
      input logic [3:0] fe, input logic [3:0] pe);
    rxValid     = mask;
    rxChar      = chars;
    rxFrameErr  = fe;
    rxParityErr = pe;
    @(negedge clk);
    rxValid     = '0;
    rxFrameErr  = '0;
    rxParityErr = '0;
  endtask

  task automatic readPop(output logic [15:0] w);
    w       = bufWord;
    bufRead = 1'b1;
    @(negedge clk);
    bufRead = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    chkEq("R1 bufWord", bufWord, 32'h0);
    chkEq("R1 rxDone", rxDone, 32'h0);
    chkEq("R1 rxIrq", rxIrq, 32'h0);
    for (int l = 0; l < 4; l++)
      chkEq("R1 lineCfg", lineCfg[l*10 +: 10], 32'h1C3);
  endtask

  task automatic testConfig();
    cfgWrite(2'd2, mkCfg(1'b1, 4'd7, 1'b0, 1'b1, 1'b0, 2'd1));
    chkEq("R2 line2 cfg", lineCfg[20 +: 10], 32'h2E9);
    chkEq("R2 line0 untouched", lineCfg[0 +: 10], 32'h1C3);
    chkEq("R2 line1 untouched", lineCfg[10 +: 10], 32'h1C3);
    chkEq("R2 line3 untouched", lineCfg[30 +: 10], 32'h1C3);
    cfgWrite(2'd2, mkCfg(1'b1, 4'd15, 1'b0, 1'b1, 1'b0, 2'd2));
    chkEq("R3 reserved baud keeps code", lineCfg[20 +: 10], 32'h2EA);
  endtask

  task automatic testDisabled();
    sendMany(4'b0010, 32'h0000_4100, 4'h0, 4'h0);
    waitN(3);
    chkEq("R4 disabled line rxDone", rxDone, 32'h0);
    chkEq("R4 disabled line word", bufWord, 32'h0);
  endtask

  task automatic testSingles();
    logic [15:0] w;
    cfgWrite(2'd0, mkCfg(1'b1, 4'd14, 1'b0, 1'b0, 1'b0, 2'd3));
    cfgWrite(2'd1, mkCfg(1'b1, 4'd14, 1'b0, 1'b0, 1'b0, 2'd0));
    cfgWrite(2'd2, mkCfg(1'b1, 4'd14, 1'b0, 1'b0, 1'b0, 2'd2));
    cfgWrite(2'd3, mkCfg(1'b1, 4'd14, 1'b0, 1'b0, 1'b0, 2'd1));
    sendMany(4'b0010, 32'h0000_FF00, 4'h0, 4'h0);
    chkEq("R10 rxDone still low one edge after arrival", rxDone, 32'h0);
    @(negedge clk);
    chkEq("R10 rxDone after push", rxDone, 32'h1);
    chkEq("R5 R6 5-bit char on line1", bufWord, 32'h811F);
    readPop(w);
    chkEq("R10 rxDone after pop", rxDone, 32'h0);
    sendMany(4'b0001, 32'h0, 4'b0001, 4'h0);
    @(negedge clk);
    readPop(w);
    chkEq("R12 break null with framing", w, 32'hA000);
    sendMany(4'b1000, 32'hFF00_0000, 4'h0, 4'b1000);
    @(negedge clk);
    readPop(w);
    chkEq("R12 R5 parity flag 6-bit line3", w, 32'h933F);
    sendMany(4'b0100, 32'h00C5_0000, 4'h0, 4'h0);
    @(negedge clk);
    readPop(w);
    chkEq("R5 7-bit char on line2", w, 32'h8245);
    waitN(3);
  endtask

  task automatic testOrder();
    logic [15:0] w;
    sendMany(4'b1011, 32'h3300_1110, 4'h0, 4'h0);
    waitN(3);
    readPop(w);
    chkEq("R7 first line0", w, 32'h8010);
    readPop(w);
    chkEq("R7 second line1", w, 32'h8111);
    readPop(w);
    chkEq("R7 third line3", w, 32'h8333);
    chkEq("R7 drained", rxDone, 32'h0);
    waitN(3);
  endtask

  task automatic testEmptyRead();
    logic [15:0] w;
    readPop(w);
    chkEq("R8 empty read word", w, 32'h0);
    chkEq("R8 empty read rxDone", rxDone, 32'h0);
    sendMany(4'b0001, 32'h0000_007E, 4'h0, 4'h0);
    @(negedge clk);
    readPop(w);
    chkEq("R8 word after empty read", w, 32'h807E);
    chkEq("R8 empty again", rxDone, 32'h0);
    waitN(3);
  endtask

  task automatic testIrq();
    logic [15:0] w;
    rxIntEn = 1'b0;
    sendMany(4'b0001, 32'h0000_0001, 4'h0, 4'h0);
    @(negedge clk);
    chkEq("R11 irq masked", rxIrq, 32'h0);
    rxIntEn = 1'b1;
    @(negedge clk);
    chkEq("R11 irq enabled with data", rxIrq, 32'h1);
    readPop(w);
    chkEq("R11 irq after drain", rxIrq, 32'h0);
    rxIntEn = 1'b0;
    waitN(3);
  endtask

  task automatic testOverflow();
    logic [15:0] w;
    for (int i = 0; i < 64; i++) begin
      sendMany(4'b0001, {24'h0, 8'(i)}, 4'h0, 4'h0);
      waitN(3);
    end
    sendMany(4'b0001, 32'h0000_00AA, 4'h0, 4'h0);
    waitN(3);
    readPop(w);
    chkEq("R9 oldest entry intact", w, 32'h8000);
    sendMany(4'b0001, 32'h0000_0055, 4'h0, 4'h0);
    waitN(3);
    for (int i = 1; i < 64; i++) begin
      readPop(w);
      chkEq("R9 stored entry", w, {16'h0, 8'h80, 8'(i)});
    end
    readPop(w);
    chkEq("R9 overrun on next stored", w, 32'hC055);
    chkEq("R9 empty at end", rxDone, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitN(3);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testDisabled();
    testSingles();
    testOrder();
    testEmptyRead();
    testIrq();
    testOverflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule